// File: doc/BRIEF.md
# Banked General-Purpose Register File

This block is the working register set of a small 8-bit processor core. It keeps four banks of eight byte-wide registers. The core reaches the active bank through two register ports. A byte port addresses one register by its 3-bit index. A pair port addresses one of four 16-bit registers, each made of two adjacent bytes. A 2-bit bank pointer picks the active bank. A select-bank control operation loads it, so that normal code and interrupt handlers can each keep their own bank and switch without saving anything.

The same 32 bytes also answer on the data-memory bus in the window 0xFEE0 to 0xFEFF. The memory port works out the bank from the address and pays no attention to the bank pointer, so any bank can be read or written as ordinary memory. Bank 0 takes the highest eight bytes of the window, and each later bank sits eight bytes lower. Within a bank the register index grows with the address. All reads are combinational. Writes and bank changes take effect on the rising clock edge.

Top module: `gpr_bank_file`

## Requirements
- R1: While rst_ni is low and after it, until the first write, bank_o is 0 and every one of the 32 registers reads 0.
- R2: rd_data_o shows register rd_idx_i of the bank in bank_o in the same cycle. When wr_en_i is high, wr_data_i is stored into register wr_idx_i of the bank in bank_o at the rising edge.
- R3: Pair k (k = 0..3) is made of register 2k as its low byte (bits 7:0) and register 2k+1 as its high byte (bits 15:8). pr_rd_data_o returns pair pr_rd_idx_i of the active bank in the same cycle. When pr_wr_en_i is high, both bytes are written at the rising edge.
- R4: When bank_we_i is high at a rising edge, bank_o takes bank_sel_i, and register and pair accesses use the new bank from the next cycle on. In the cycle of the select, accesses still use the old bank. While bank_we_i is low, bank_o holds its value.
- R5: A memory address A in 0xFEE0..0xFEFF drives mem_hit_o high and maps to register n of bank b, where A = 0xFEF8 − 8·b + n. mem_rd_data_o shows that register in the same cycle, and mem_wr_en_i writes mem_wr_data_i into it at the rising edge.
- R6: The memory port ignores bank_o and bank_sel_i. It reaches any bank whatever bank is active.
- R7: For an address outside 0xFEE0..0xFEFF, mem_hit_o is 0 and mem_rd_data_o is 0, and a memory write changes no register. This includes addresses that match the window only in their low five bits.
- R8: When writes from several ports land on the same byte in the same cycle, the byte port wins over the pair port, and the pair port wins over the memory port. Writes to different bytes in the same cycle all take effect.
- R9: A read of a byte that is being written in the same cycle returns the old value. The new value shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_we_i | input | 1 | Select-bank operation strobe |
| bank_sel_i | input | 2 | Bank to select |
| bank_o | output | 2 | Active bank |
| rd_idx_i | input | 3 | Byte-port read index |
| rd_data_o | output | 8 | Byte-port read data |
| wr_en_i | input | 1 | Byte-port write enable |
| wr_idx_i | input | 3 | Byte-port write index |
| wr_data_i | input | 8 | Byte-port write data |
| pr_rd_idx_i | input | 2 | Pair-port read index |
| pr_rd_data_o | output | 16 | Pair-port read data |
| pr_wr_en_i | input | 1 | Pair-port write enable |
| pr_wr_idx_i | input | 2 | Pair-port write index |
| pr_wr_data_i | input | 16 | Pair-port write data |
| mem_addr_i | input | 16 | Data-memory address |
| mem_wr_en_i | input | 1 | Data-memory write enable |
| mem_wr_data_i | input | 8 | Data-memory write data |
| mem_rd_data_o | output | 8 | Data-memory read data, 0 on a miss |
| mem_hit_o | output | 1 | Address lies in the register window |

## Verification
Read data and the hit flag are combinational, so they are due in the same cycle as the address. Stored data and a new bank are due one rising edge after the enable. The bench changes inputs on the falling edge and checks combinational results 1 ns later. It checks written data and bank_o only after the next rising edge. The two cases that span an edge are the no-bypass read (R9) and the bank-switch cycle (R4). For these the bench checks once before the rising edge and once just after it, so the value each side of the edge is pinned.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // Winner of the per-byte write arbitration
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_BYTE,
    SRC_PAIR,
    SRC_MEM
  } wr_src_e;
endpackage

// File: rtl/gpr_bank_sel.sv
module gpr_bank_sel #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] sel_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_q <= '0;
    else if (we_i) bank_q <= sel_i;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/gpr_win_decode.sv
module gpr_win_decode #(
  parameter int unsigned       NUM_BANKS = 4,
  parameter int unsigned       BANK_W    = 2,
  parameter int unsigned       IDX_W     = 3,
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFEE0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned OFS_W = BANK_W + IDX_W;

  logic [BANK_W-1:0] slot;

  // Window base is aligned to its size; bank 0 occupies the top slot
  assign hit_o  = (addr_i[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
  assign slot   = addr_i[OFS_W-1:IDX_W];
  assign bank_o = BANK_W'(NUM_BANKS - 1) - slot;
  assign idx_o  = addr_i[IDX_W-1:0];
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage import gpr_pkg::*; #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ENT_W   = 5,
  localparam int unsigned ENTRIES = 1 << ENT_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            byte_we_i,
  input  logic [ENT_W-1:0]                byte_ent_i,
  input  logic [DATA_W-1:0]               byte_data_i,
  input  logic                            pair_we_i,
  input  logic [ENT_W-2:0]                pair_ent_i,
  input  logic [2*DATA_W-1:0]             pair_data_i,
  input  logic                            mem_we_i,
  input  logic [ENT_W-1:0]                mem_ent_i,
  input  logic [DATA_W-1:0]               mem_data_i,
  output logic [ENTRIES-1:0][DATA_W-1:0]  q_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [ENT_W-1:0] ENT = ENT_W'(e);
    localparam bit               HI  = (e % 2) == 1;

    wr_src_e           src;
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] pair_half;

    assign pair_half = HI ? pair_data_i[2*DATA_W-1:DATA_W] : pair_data_i[DATA_W-1:0];

    // Byte port over pair port over memory port
    always_comb begin
      if (byte_we_i && byte_ent_i == ENT)                 src = SRC_BYTE;
      else if (pair_we_i && pair_ent_i == ENT[ENT_W-1:1]) src = SRC_PAIR;
      else if (mem_we_i && mem_ent_i == ENT)              src = SRC_MEM;
      else                                                src = SRC_NONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
      end else begin
        case (src)
          SRC_BYTE: val_q <= byte_data_i;
          SRC_PAIR: val_q <= pair_half;
          SRC_MEM:  val_q <= mem_data_i;
          default:  ;
        endcase
      end
    end

    assign q_o[e] = val_q;
  end
endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file #(
  parameter int unsigned       NUM_BANKS     = 4,
  parameter int unsigned       REGS_PER_BANK = 8,
  parameter int unsigned       DATA_W        = 8,
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE      = 16'hFEE0,
  localparam int unsigned      BANK_W        = $clog2(NUM_BANKS),
  localparam int unsigned      IDX_W         = $clog2(REGS_PER_BANK),
  localparam int unsigned      PAIR_W        = IDX_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bank_we_i,
  input  logic [BANK_W-1:0]   bank_sel_i,
  output logic [BANK_W-1:0]   bank_o,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [PAIR_W-1:0]   pr_rd_idx_i,
  output logic [2*DATA_W-1:0] pr_rd_data_o,
  input  logic                pr_wr_en_i,
  input  logic [PAIR_W-1:0]   pr_wr_idx_i,
  input  logic [2*DATA_W-1:0] pr_wr_data_i,
  input  logic [ADDR_W-1:0]   mem_addr_i,
  input  logic                mem_wr_en_i,
  input  logic [DATA_W-1:0]   mem_wr_data_i,
  output logic [DATA_W-1:0]   mem_rd_data_o,
  output logic                mem_hit_o
);
  localparam int unsigned ENT_W   = BANK_W + IDX_W;
  localparam int unsigned ENTRIES = 1 << ENT_W;

  logic [BANK_W-1:0]               bank_q;
  logic [BANK_W-1:0]               mem_bank;
  logic [IDX_W-1:0]                mem_idx;
  logic                            mem_hit;
  logic [ENTRIES-1:0][DATA_W-1:0]  regs;

  gpr_bank_sel #(
    .BANK_W (BANK_W)
  ) u_bank_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we_i),
    .sel_i  (bank_sel_i),
    .bank_o (bank_q)
  );

  gpr_win_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE)
  ) u_win_decode (
    .addr_i (mem_addr_i),
    .hit_o  (mem_hit),
    .bank_o (mem_bank),
    .idx_o  (mem_idx)
  );

  gpr_storage #(
    .DATA_W (DATA_W),
    .ENT_W  (ENT_W)
  ) u_storage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_we_i   (wr_en_i),
    .byte_ent_i  ({bank_q, wr_idx_i}),
    .byte_data_i (wr_data_i),
    .pair_we_i   (pr_wr_en_i),
    .pair_ent_i  ({bank_q, pr_wr_idx_i}),
    .pair_data_i (pr_wr_data_i),
    .mem_we_i    (mem_wr_en_i & mem_hit),
    .mem_ent_i   ({mem_bank, mem_idx}),
    .mem_data_i  (mem_wr_data_i),
    .q_o         (regs)
  );

  assign bank_o        = bank_q;
  assign rd_data_o     = regs[{bank_q, rd_idx_i}];
  assign pr_rd_data_o  = {regs[{bank_q, pr_rd_idx_i, 1'b1}], regs[{bank_q, pr_rd_idx_i, 1'b0}]};
  assign mem_rd_data_o = mem_hit ? regs[{mem_bank, mem_idx}] : '0;
  assign mem_hit_o     = mem_hit;
endmodule

module gpr_bank_file_chk #(
  parameter int unsigned       NUM_BANKS     = 4,
  parameter int unsigned       REGS_PER_BANK = 8,
  parameter int unsigned       DATA_W        = 8,
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE      = 16'hFEE0,
  localparam int unsigned      BANK_W        = $clog2(NUM_BANKS),
  localparam int unsigned      IDX_W         = $clog2(REGS_PER_BANK),
  localparam int unsigned      PAIR_W        = IDX_W - 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bank_we_i,
  input logic [BANK_W-1:0]   bank_sel_i,
  input logic [BANK_W-1:0]   bank_o,
  input logic [IDX_W-1:0]    rd_idx_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic                wr_en_i,
  input logic [IDX_W-1:0]    wr_idx_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [PAIR_W-1:0]   pr_rd_idx_i,
  input logic [2*DATA_W-1:0] pr_rd_data_o,
  input logic                pr_wr_en_i,
  input logic [PAIR_W-1:0]   pr_wr_idx_i,
  input logic [2*DATA_W-1:0] pr_wr_data_i,
  input logic [ADDR_W-1:0]   mem_addr_i,
  input logic                mem_wr_en_i,
  input logic [DATA_W-1:0]   mem_wr_data_i,
  input logic [DATA_W-1:0]   mem_rd_data_o,
  input logic                mem_hit_o
);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(NUM_BANKS * REGS_PER_BANK - 1);

  p_bank_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_o == $past(bank_sel_i));

  p_bank_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we_i |=> $stable(bank_o));

  p_window_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit_o == ((mem_addr_i >= WIN_BASE) && (mem_addr_i <= WIN_LAST)));

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_hit_o |-> mem_rd_data_o == '0);

  // Byte port always lands (R8 top priority), visible next cycle in same bank
  p_byte_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!(rd_idx_i == $past(wr_idx_i) && bank_o == $past(bank_o))
                 || rd_data_o == $past(wr_data_i)));

  p_pair_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_wr_en_i && !wr_en_i) |=> (!(pr_rd_idx_i == $past(pr_wr_idx_i) && bank_o == $past(bank_o))
                                  || pr_rd_data_o == $past(pr_wr_data_i)));

  p_mem_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_en_i && mem_hit_o && !wr_en_i && !pr_wr_en_i) |=>
      (mem_addr_i != $past(mem_addr_i) || mem_rd_data_o == $past(mem_wr_data_i)));
endmodule

bind gpr_bank_file gpr_bank_file_chk u_chk (.*);

// File: tb/tb_gpr_bank_file.sv
module tb_gpr_bank_file;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_we_i = 1'b0;
  logic [1:0]  bank_sel_i = '0;
  logic [1:0]  bank_o;
  logic [2:0]  rd_idx_i = '0;
  logic [7:0]  rd_data_o;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [1:0]  pr_rd_idx_i = '0;
  logic [15:0] pr_rd_data_o;
  logic        pr_wr_en_i = 1'b0;
  logic [1:0]  pr_wr_idx_i = '0;
  logic [15:0] pr_wr_data_i = '0;
  logic [15:0] mem_addr_i = '0;
  logic        mem_wr_en_i = 1'b0;
  logic [7:0]  mem_wr_data_i = '0;
  logic [7:0]  mem_rd_data_o;
  logic        mem_hit_o;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  int   cur = 0;
  logic [7:0] mdl [4][8];

  always #4 clk = ~clk;

  gpr_bank_file dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bank_we_i    (bank_we_i),
    .bank_sel_i   (bank_sel_i),
    .bank_o       (bank_o),
    .rd_idx_i     (rd_idx_i),
    .rd_data_o    (rd_data_o),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_data_i    (wr_data_i),
    .pr_rd_idx_i  (pr_rd_idx_i),
    .pr_rd_data_o (pr_rd_data_o),
    .pr_wr_en_i   (pr_wr_en_i),
    .pr_wr_idx_i  (pr_wr_idx_i),
    .pr_wr_data_i (pr_wr_data_i),
    .mem_addr_i   (mem_addr_i),
    .mem_wr_en_i  (mem_wr_en_i),
    .mem_wr_data_i(mem_wr_data_i),
    .mem_rd_data_o(mem_rd_data_o),
    .mem_hit_o    (mem_hit_o)
  );

  function automatic logic [15:0] addr_of(int b, int n);
    return 16'hFEF8 - 16'(8 * b) + 16'(n);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic sel_bank(input int b);
    @(negedge clk);
    bank_sel_i = 2'(b);
    bank_we_i  = 1'b1;
    @(posedge clk); #1;
    bank_we_i  = 1'b0;
    cur = b;
  endtask

  task automatic wr_byte(input int n, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'(n); wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    mdl[cur][n] = d;
  endtask

  task automatic wr_pair(input int p, input logic [15:0] d);
    @(negedge clk);
    pr_wr_en_i = 1'b1; pr_wr_idx_i = 2'(p); pr_wr_data_i = d;
    @(posedge clk); #1;
    pr_wr_en_i = 1'b0;
    mdl[cur][2*p]   = d[7:0];
    mdl[cur][2*p+1] = d[15:8];
  endtask

  task automatic wr_mem(input int b, input int n, input logic [7:0] d);
    @(negedge clk);
    mem_wr_en_i = 1'b1; mem_addr_i = addr_of(b, n); mem_wr_data_i = d;
    @(posedge clk); #1;
    mem_wr_en_i = 1'b0;
    mdl[b][n] = d;
  endtask

  task automatic rd_byte_chk(input int n, input string tag);
    @(negedge clk);
    rd_idx_i = 3'(n);
    #1;
    chk(tag, 16'(rd_data_o), 16'(mdl[cur][n]));
  endtask

  task automatic rd_pair_chk(input int p, input string tag);
    @(negedge clk);
    pr_rd_idx_i = 2'(p);
    #1;
    chk(tag, pr_rd_data_o, {mdl[cur][2*p+1], mdl[cur][2*p]});
  endtask

  task automatic rd_mem_chk(input int b, input int n, input string tag);
    @(negedge clk);
    mem_addr_i = addr_of(b, n);
    #1;
    chk(tag, 16'(mem_rd_data_o), 16'(mdl[b][n]));
    chk(tag, 16'(mem_hit_o), 16'd1);
  endtask

  task automatic sweep_mem(input string tag);
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++)
        rd_mem_chk(b, n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] miss [5];
    miss = '{16'hFEDF, 16'hFF00, 16'h0000, 16'hFEC3, 16'h7EE0};
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++)
        mdl[b][n] = 8'h00;

    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is still held and after release
    #1 chk("R1 bank in reset", 16'(bank_o), 16'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R1 bank after reset", 16'(bank_o), 16'd0);
    sweep_mem("R1 R5 cleared registers");

    // R6: fill every bank through memory while bank 2 is active
    sel_bank(2);
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++)
        wr_mem(b, n, 8'(b * 37 + n * 11 + 5));
    rd_mem_chk(0, 3, "R6 memory reaches bank 0 with bank 2 active");
    chk("R6 bank unchanged by memory writes", 16'(bank_o), 16'd2);

    // R2 R3 R4 R5: each bank through register and pair ports
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      chk("R4 bank after select", 16'(bank_o), 16'(b));
      for (int n = 0; n < 8; n++) rd_byte_chk(n, "R2 R5 byte read of memory fill");
      for (int p = 0; p < 4; p++) rd_pair_chk(p, "R3 pair read of memory fill");
    end

    // R2: byte writes in every bank, read back through the window
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      for (int n = 0; n < 8; n++) wr_byte(n, ~8'(b * 16 + n));
    end
    sweep_mem("R2 R5 byte writes seen in window");

    // R3: pair writes, low byte at even index
    sel_bank(1);
    for (int p = 0; p < 4; p++) wr_pair(p, 16'hA05C + 16'(p * 16'h0313));
    for (int n = 0; n < 8; n++) rd_byte_chk(n, "R3 pair bytes via byte port");
    for (int n = 0; n < 8; n++) rd_mem_chk(1, n, "R3 pair bytes via window");
    rd_mem_chk(0, 0, "R3 other bank untouched");

    // R4: switch cycle uses old bank, next cycle new bank
    @(negedge clk);
    bank_sel_i = 2'd3; bank_we_i = 1'b1; rd_idx_i = 3'd0;
    #1;
    chk("R4 bank before edge", 16'(bank_o), 16'd1);
    chk("R4 read uses old bank", 16'(rd_data_o), 16'(mdl[1][0]));
    @(posedge clk); #1;
    bank_we_i = 1'b0; cur = 3;
    chk("R4 bank after edge", 16'(bank_o), 16'd3);
    chk("R4 read uses new bank", 16'(rd_data_o), 16'(mdl[3][0]));
    @(negedge clk);
    bank_sel_i = 2'd0;
    @(posedge clk); #1;
    chk("R4 bank holds without strobe", 16'(bank_o), 16'd3);

    // R9: no bypass in the write cycle
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'd5; wr_data_i = 8'hE1;
    rd_idx_i = 3'd5; mem_addr_i = addr_of(3, 5);
    #1;
    chk("R9 byte read old value", 16'(rd_data_o), 16'(mdl[3][5]));
    chk("R9 window read old value", 16'(mem_rd_data_o), 16'(mdl[3][5]));
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    mdl[3][5] = 8'hE1;
    @(negedge clk); #1;
    chk("R9 byte read new value", 16'(rd_data_o), 16'h00E1);
    chk("R9 window read new value", 16'(mem_rd_data_o), 16'h00E1);

    // R8: byte over memory on the same byte
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'd4; wr_data_i = 8'h5A;
    mem_wr_en_i = 1'b1; mem_addr_i = addr_of(3, 4); mem_wr_data_i = 8'hC3;
    @(posedge clk); #1;
    wr_en_i = 1'b0; mem_wr_en_i = 1'b0;
    mdl[3][4] = 8'h5A;
    rd_byte_chk(4, "R8 byte beats memory");
    // R8: byte over pair on the low byte of pair 1
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'd2; wr_data_i = 8'h77;
    pr_wr_en_i = 1'b1; pr_wr_idx_i = 2'd1; pr_wr_data_i = 16'hBEEF;
    @(posedge clk); #1;
    wr_en_i = 1'b0; pr_wr_en_i = 1'b0;
    mdl[3][2] = 8'h77; mdl[3][3] = 8'hBE;
    rd_pair_chk(1, "R8 byte beats pair low, pair high lands");
    // R8: pair over memory on the high byte of pair 1
    @(negedge clk);
    pr_wr_en_i = 1'b1; pr_wr_idx_i = 2'd1; pr_wr_data_i = 16'h1234;
    mem_wr_en_i = 1'b1; mem_addr_i = addr_of(3, 3); mem_wr_data_i = 8'h99;
    @(posedge clk); #1;
    pr_wr_en_i = 1'b0; mem_wr_en_i = 1'b0;
    mdl[3][2] = 8'h34; mdl[3][3] = 8'h12;
    rd_pair_chk(1, "R8 pair beats memory");
    // R8: disjoint bytes both land, memory in another bank
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'd0; wr_data_i = 8'h01;
    mem_wr_en_i = 1'b1; mem_addr_i = addr_of(0, 7); mem_wr_data_i = 8'h02;
    @(posedge clk); #1;
    wr_en_i = 1'b0; mem_wr_en_i = 1'b0;
    mdl[3][0] = 8'h01; mdl[0][7] = 8'h02;
    rd_byte_chk(0, "R8 disjoint byte write");
    rd_mem_chk(0, 7, "R8 disjoint memory write");

    // R7: misses read zero and write nothing
    foreach (miss[i]) begin
      @(negedge clk);
      mem_addr_i = miss[i]; mem_wr_en_i = 1'b1; mem_wr_data_i = 8'hAA;
      #1;
      chk("R7 miss flag", 16'(mem_hit_o), 16'd0);
      chk("R7 miss data", 16'(mem_rd_data_o), 16'd0);
      @(posedge clk); #1;
      mem_wr_en_i = 1'b0;
    end
    sweep_mem("R7 registers unchanged by missed writes");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule